// File: doc/BRIEF.md
# Cascaded Acquisition Sample Counter

This block decides when a data-acquisition run has taken enough samples. Every accepted conversion strobe decrements a low down counter. In 32-bit mode a high down counter is chained behind it, so the sample total can exceed one counter's range. Software supplies three values through parallel load ports:

- the first low value;
- the value the low counter takes on each later pass;
- the high value.

A load strobe copies these values into the counters and latches the width mode. An arm strobe then enables acquisition.

The run ends on a conversion that arrives while the counters that take part all read zero, with the scan list reporting its last entry. On that edge the block drops its enable output and raises a done pulse for one cycle. It then stays idle until it is armed again.

For a total of N = H·65536 + L samples, software loads the values as follows:

- The low counter gets L−1, or 16'hFFFF when L is 0.
- The low reload port gets 0.
- The high counter gets H when L is 0 or 1, and H+1 for any other L.

Top module: `acq_sample_counter`

## Requirements
- R1: A synchronous active-high `rst` clears both counters to zero, disarms the block (`acq_en_o` low), clears `done_o` and selects 16-bit mode. A conversion after re-arming then ends the run at once.
- R2: `load_i` copies `lo_init_i` into the low counter, `hi_init_i` into the high counter and `mode32_i` into the mode register (1 = 32-bit, 0 = 16-bit). A conversion in the same cycle as a load is dropped, and the loaded values take effect unchanged.
- R3: `arm_i` raises `acq_en_o` on the following clock edge. While `acq_en_o` is low, conversion strobes change neither counter.
- R4: Each accepted conversion decrements the low counter by one. In 16-bit mode, a low value of L−1 (L ≥ 1) ends the run on exactly the L-th conversion.
- R5: A conversion that finds the low counter at zero, outside the final condition, reloads it with `lo_reload_i` − 1 modulo 2^16. A reload of 0 therefore gives a pass of 65536 conversions.
- R6: In 32-bit mode the high counter decrements once each time the low counter steps from 1 to 0. In 16-bit mode the high counter never changes and does not affect the stop.
- R7: In 32-bit mode the run ends only on a conversion that finds both counters at zero. With the load rule above, the run lasts exactly N conversions for H = 0, L ≥ 1 and for H ≥ 1 with any L.
- R8: A conversion that meets the zero condition while `scan_last_i` is low keeps the counters at zero and leaves `acq_en_o` high. The next conversion with `scan_last_i` high ends the run.
- R9: The run ends with `done_o` high for exactly one cycle, and `acq_en_o` falls in that same cycle. Later conversions are ignored until the block is re-armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode32_i | input | 1 | Width mode latched on load (1 = cascaded 32-bit) |
| lo_init_i | input | 16 | First low counter value |
| lo_reload_i | input | 16 | Low pass value (0 means 65536) |
| hi_init_i | input | 16 | High counter value |
| load_i | input | 1 | Load strobe |
| arm_i | input | 1 | Arm strobe |
| conv_i | input | 1 | Conversion strobe, one cycle per sample |
| scan_last_i | input | 1 | Last scan list entry is being served |
| acq_en_o | output | 1 | Acquisition enabled |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
Two events can fall on the same cycle: a load strobe and a conversion strobe. The bench provokes this in the middle of a 16-bit run. It then counts the conversions that remain before `done_o`: the count must equal the fresh load value plus one, with no conversion lost to or taken from the colliding one. A second coincidence is built into the logic. A conversion that moves the low counter to zero is the same conversion that steps the high counter. The 32-bit tests check this by requiring exact total lengths of 7, 9, 65536 and 65537 conversions.

// File: rtl/acq_cnt_pkg.sv
package acq_cnt_pkg;
  localparam int unsigned CNT_W = 16;
endpackage

// File: rtl/acq_lo_counter.sv
module acq_lo_counter #(
  parameter int unsigned W = acq_cnt_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] init_i,
  input  logic [W-1:0] reload_i,
  input  logic         step_i,
  input  logic         hold_i,
  output logic [W-1:0] q_o,
  output logic         zero_o,
  output logic         reach_o
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= '0;
    end else if (load_i) begin
      q_o <= init_i;
    end else if (step_i) begin
      if (q_o == '0) begin
        if (!hold_i) q_o <= reload_i - ONE;
      end else begin
        q_o <= q_o - ONE;
      end
    end
  end

  assign zero_o  = (q_o == '0);
  assign reach_o = step_i && (q_o == ONE);

  // R8
  hold_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    step_i && hold_i && !load_i |=> zero_o);
endmodule

// File: rtl/acq_hi_counter.sv
module acq_hi_counter #(
  parameter int unsigned W = acq_cnt_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] init_i,
  input  logic         step_i,
  output logic [W-1:0] q_o,
  output logic         zero_o
);
  always_ff @(posedge clk) begin
    if (rst)         q_o <= '0;
    else if (load_i) q_o <= init_i;
    else if (step_i) q_o <= q_o - W'(1);
  end

  assign zero_o = (q_o == '0);
endmodule

// File: rtl/acq_stop_ctrl.sv
module acq_stop_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic mode32_i,
  input  logic arm_i,
  input  logic conv_i,
  input  logic scan_last_i,
  input  logic lo_zero_i,
  input  logic hi_zero_i,
  output logic step_o,
  output logic hold_o,
  output logic mode32_o,
  output logic acq_en_o,
  output logic done_o
);
  logic fire;

  assign step_o = conv_i && acq_en_o && !load_i;
  assign hold_o = lo_zero_i && (hi_zero_i || !mode32_o);
  assign fire   = step_o && hold_o && scan_last_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      acq_en_o <= 1'b0;
      done_o   <= 1'b0;
      mode32_o <= 1'b0;
    end else begin
      done_o <= fire;
      if (load_i) mode32_o <= mode32_i;
      if (fire)       acq_en_o <= 1'b0;
      else if (arm_i) acq_en_o <= 1'b1;
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R9
  done_disarms_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !acq_en_o);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !acq_en_o && !done_o);
endmodule

// File: rtl/acq_sample_counter.sv
module acq_sample_counter #(
  parameter int unsigned W = acq_cnt_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode32_i,
  input  logic [W-1:0] lo_init_i,
  input  logic [W-1:0] lo_reload_i,
  input  logic [W-1:0] hi_init_i,
  input  logic         load_i,
  input  logic         arm_i,
  input  logic         conv_i,
  input  logic         scan_last_i,
  output logic         acq_en_o,
  output logic         done_o
);
  logic [W-1:0] lo_q, hi_q;
  logic lo_zero, lo_reach, hi_zero, step, hold, mode32_q, hi_step;

  assign hi_step = lo_reach && mode32_q;

  acq_lo_counter #(.W(W)) i_lo (
    .clk(clk), .rst(rst), .load_i(load_i), .init_i(lo_init_i),
    .reload_i(lo_reload_i), .step_i(step), .hold_i(hold),
    .q_o(lo_q), .zero_o(lo_zero), .reach_o(lo_reach)
  );

  acq_hi_counter #(.W(W)) i_hi (
    .clk(clk), .rst(rst), .load_i(load_i), .init_i(hi_init_i),
    .step_i(hi_step), .q_o(hi_q), .zero_o(hi_zero)
  );

  acq_stop_ctrl i_ctrl (
    .clk(clk), .rst(rst), .load_i(load_i), .mode32_i(mode32_i),
    .arm_i(arm_i), .conv_i(conv_i), .scan_last_i(scan_last_i),
    .lo_zero_i(lo_zero), .hi_zero_i(hi_zero), .step_o(step),
    .hold_o(hold), .mode32_o(mode32_q), .acq_en_o(acq_en_o), .done_o(done_o)
  );

  // R3
  idle_conv_chk: assert property (@(posedge clk) disable iff (rst)
    !acq_en_o && !load_i |=> $stable(lo_q) && $stable(hi_q));
  // R6
  hi_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    !mode32_q && !load_i |=> $stable(hi_q));
  // R7
  done_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> lo_zero && (hi_zero || !mode32_q));
endmodule

// File: tb/test_acq_sample_counter.sv
module test_acq_sample_counter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 180000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode32_i = 1'b0, load_i = 1'b0, arm_i = 1'b0, conv_i = 1'b0;
  logic scan_last_i = 1'b1;
  logic [15:0] lo_init_i = '0, lo_reload_i = '0, hi_init_i = '0;
  logic acq_en_o, done_o;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acq_sample_counter i_acq_sample_counter (
    .clk(clk), .rst(rst), .mode32_i(mode32_i), .lo_init_i(lo_init_i),
    .lo_reload_i(lo_reload_i), .hi_init_i(hi_init_i), .load_i(load_i),
    .arm_i(arm_i), .conv_i(conv_i), .scan_last_i(scan_last_i),
    .acq_en_o(acq_en_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic do_load(input logic [15:0] lo, input logic [15:0] hi,
                         input logic [15:0] rl, input logic m);
    lo_init_i = lo; hi_init_i = hi; lo_reload_i = rl; mode32_i = m;
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic do_arm(input string req);
    arm_i = 1'b1;
    @(negedge clk);
    arm_i = 1'b0;
    check(acq_en_o == 1'b1, req, int'(acq_en_o), 1);
  endtask

  task automatic run_until_done(input int limit, output int n);
    n = 0;
    forever begin
      conv_i = 1'b1;
      n++;
      @(negedge clk);
      if (done_o || n >= limit) break;
    end
    conv_i = 1'b0;
  endtask

  task automatic expect_run(input int exp, input string req);
    int n;
    run_until_done(exp + 4, n);
    check(n == exp && done_o, req, n, exp);
    check(!acq_en_o, req, int'(acq_en_o), 0);
    @(negedge clk);
    check(!done_o, req, int'(done_o), 0);
  endtask

  task automatic t_reset();
    check(!acq_en_o && !done_o, "R1", int'({acq_en_o, done_o}), 0);
    do_arm("R3");
    expect_run(1, "R1");
    do_load(16'd9, 16'd0, 16'd0, 1'b1);
    do_arm("R3");
    conv_i = 1'b1; repeat (2) @(negedge clk); conv_i = 1'b0;
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check(!acq_en_o, "R1", int'(acq_en_o), 0);
    do_arm("R3");
    expect_run(1, "R1");
  endtask

  task automatic t_16bit();
    do_load(16'd4, 16'd5, 16'd0, 1'b0);
    do_arm("R3");
    expect_run(5, "R4 R6");
  endtask

  task automatic t_disarmed();
    do_load(16'd2, 16'd0, 16'd0, 1'b0);
    conv_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!done_o && !acq_en_o, "R3", int'({done_o, acq_en_o}), 0);
    end
    conv_i = 1'b0;
    do_arm("R3");
    expect_run(3, "R3");
  endtask

  task automatic t_scan_gate();
    do_load(16'd1, 16'd0, 16'd0, 1'b0);
    do_arm("R3");
    scan_last_i = 1'b0;
    conv_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!done_o && acq_en_o, "R8", int'({done_o, acq_en_o}), 1);
    end
    scan_last_i = 1'b1;
    expect_run(1, "R8");
  endtask

  task automatic t_rearm();
    do_load(16'd0, 16'd0, 16'd0, 1'b0);
    do_arm("R3");
    expect_run(1, "R9");
    conv_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!done_o && !acq_en_o, "R9", int'({done_o, acq_en_o}), 0);
    end
    conv_i = 1'b0;
    do_arm("R3");
    expect_run(1, "R9");
  endtask

  task automatic t_collide();
    do_load(16'd3, 16'd0, 16'd0, 1'b0);
    do_arm("R3");
    conv_i = 1'b1; repeat (2) @(negedge clk);
    lo_init_i = 16'd3; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0; conv_i = 1'b0;
    check(acq_en_o && !done_o, "R2", int'({acq_en_o, done_o}), 2);
    expect_run(4, "R2");
  endtask

  task automatic t_32_small();
    do_load(16'd6, 16'd1, 16'd0, 1'b1);
    do_arm("R3");
    expect_run(7, "R7");
  endtask

  task automatic t_32_reload();
    do_load(16'd0, 16'd2, 16'd4, 1'b1);
    do_arm("R3");
    expect_run(9, "R5 R6");
  endtask

  task automatic t_32_long_l1();
    do_load(16'd0, 16'd1, 16'd0, 1'b1);
    do_arm("R3");
    expect_run(65537, "R5 R7");
  endtask

  task automatic t_32_long_l0();
    do_load(16'hFFFF, 16'd1, 16'd0, 1'b1);
    do_arm("R3");
    expect_run(65536, "R7");
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected 0 cycles left", WATCHDOG);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_16bit();
    t_disarmed();
    t_scan_gate();
    t_rearm();
    t_collide();
    t_32_small();
    t_32_reload();
    t_32_long_l1();
    t_32_long_l0();
    finish_run();
  end
endmodule